// File: doc/BRIEF.md
# Software Flow-Control Code Injector

This block sits beside a UART transmitter and decides when the local receiver must tell the remote sender to pause or resume. It watches the receive FIFO fill level against either a pair of programmable limits or a selectable trigger step. When the level rises past the halt limit, it queues a pause code. When the level falls back to the resume limit, it queues a continue code. The halt and resume limits are separate, so the block has hysteresis and sends each code only once per crossing.

A queued code is offered to the serializer ahead of any transmit FIFO data, and only at a character boundary. A 2-bit mode sets what is sent. The block can send nothing, code set 1, code set 2, or set 1 followed at once by set 2. Codes are framed like data, so a 5-, 6- or 7-bit word length keeps only the low bits of the code. The block assumes that hardware handshake automation is off while it is in use.

Top module: `xcode_tx_sched`

## Requirements
- R1: After reset, `inj_valid` is 0 and no pause state is in effect.
- R2: In limit mode (`use_trig`=0), with no pause in effect, a level strictly above `halt_th` queues one pause sequence. The level staying high queues nothing further.
- R3: In limit mode, with a pause in effect, a level at or below `resume_th` queues one continue sequence.
- R4: In step mode (`use_trig`=1) the upper step is DEPTH/8, DEPTH/4, DEPTH−DEPTH/8 or DEPTH−DEPTH/16 for `trig_sel` 0..3. A pause is queued when the level is above that step. A continue is queued when the level is below half of it (integer division).
- R5: `tx_mode` 2'b10 sends code 1 of the kind (xon1/xoff1) and 2'b01 sends code 2 (xon2/xoff2). 2'b11 sends code 1 then code 2. 2'b00 never raises `inj_valid`.
- R6: `word_len` 0,1,2,3 selects 5,6,7,8 bits. `inj_code` carries the code's low bits with all higher bits zero.
- R7: `fifo_go` equals `tx_ready` when nothing is queued and is 0 while `inj_valid` is 1. A queued code stays offered until `tx_ready` accepts it.
- R8: In mode 2'b11, the cycle after code 1 is accepted offers code 2, with no FIFO slot in between.
- R9: If the level crosses back before a queued code is accepted, the offered code becomes the opposite kind.
- R10: In a single-code mode, `inj_valid` is 0 in the cycle after the code is accepted, unless a new crossing occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_th | input | LVL_W | Pause limit (limit mode) |
| resume_th | input | LVL_W | Resume limit (limit mode) |
| use_trig | input | 1 | 1 selects step mode, 0 selects limit mode |
| trig_sel | input | 2 | Step selection |
| tx_mode | input | 2 | Code transmit mode |
| xon1 | input | 8 | Continue code 1 |
| xon2 | input | 8 | Continue code 2 |
| xoff1 | input | 8 | Pause code 1 |
| xoff2 | input | 8 | Pause code 2 |
| word_len | input | 2 | Character length select (5..8 bits) |
| tx_ready | input | 1 | Serializer is at a character boundary and takes a character this cycle |
| inj_valid | output | 1 | A code is offered |
| inj_code | output | 8 | Offered code, truncated to the word length |
| fifo_go | output | 1 | The FIFO data path may supply this character |

## Verification
The bench builds the block with DEPTH=16, which gives a 5-bit level. Every level from empty to full can then be ramped in both directions within a few dozen cycles. This small size lets the bench cover every step selection, four limit pairs, all three active modes and all four word lengths exhaustively. For each combination, the bench checks the exact level at which each code is queued and the truncated value of every code byte.

// File: rtl/xcg_pkg.sv
package xcg_pkg;

  typedef enum logic {
    KIND_XON  = 1'b0,
    KIND_XOFF = 1'b1
  } code_kind_e;

  // upper step of the selectable trigger ladder
  function automatic int step_hi(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth - depth / 8;
      default: return depth - depth / 16;
    endcase
  endfunction

  // resume point of the ladder: half of the upper step
  function automatic int step_lo(input logic [1:0] sel, input int depth);
    return step_hi(sel, depth) / 2;
  endfunction

  // keep 5..8 low bits
  function automatic logic [7:0] len_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

endpackage

// File: rtl/xcg_level_mon.sv
module xcg_level_mon #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_th,
  input  logic [LVL_W-1:0] resume_th,
  input  logic             use_trig,
  input  logic [1:0]       trig_sel,
  output logic             xoff_q,
  output logic             ev_halt,
  output logic             ev_resume
);
  import xcg_pkg::*;

  int  lvl;
  logic over_halt, under_resume;

  always_comb begin
    lvl = int'(rx_level);
    if (use_trig) begin
      over_halt    = lvl > step_hi(trig_sel, DEPTH);
      under_resume = lvl < step_lo(trig_sel, DEPTH);
    end else begin
      over_halt    = lvl > int'(halt_th);
      under_resume = lvl <= int'(resume_th);
    end
    ev_halt   = en && !xoff_q && over_halt;
    ev_resume = en && xoff_q && under_resume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         xoff_q <= 1'b0;
    else if (!en)       xoff_q <= 1'b0;
    else if (ev_halt)   xoff_q <= 1'b1;
    else if (ev_resume) xoff_q <= 1'b0;
  end

endmodule

// File: rtl/xcg_seq.sv
module xcg_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                pair_mode,
  input  logic                ev_halt,
  input  logic                ev_resume,
  input  logic                accept,
  output logic                pend,
  output xcg_pkg::code_kind_e kind,
  output logic                idx
);
  import xcg_pkg::*;

  logic       requeue, n_requeue, n_pend, n_idx;
  code_kind_e rq_kind, n_rq_kind, n_kind, ev_kind;

  always_comb begin
    n_pend    = pend;
    n_kind    = kind;
    n_idx     = idx;
    n_requeue = requeue;
    n_rq_kind = rq_kind;
    ev_kind   = ev_halt ? KIND_XOFF : KIND_XON;

    if (accept && pend) begin
      if (pair_mode && !idx) begin
        n_idx = 1'b1;
      end else begin
        n_pend    = requeue;
        n_kind    = rq_kind;
        n_idx     = 1'b0;
        n_requeue = 1'b0;
      end
    end

    if (ev_halt || ev_resume) begin
      if (n_pend && n_idx) begin
        // second byte of a pair still owed: run the new event afterwards
        n_requeue = 1'b1;
        n_rq_kind = ev_kind;
      end else begin
        n_pend = 1'b1;
        n_kind = ev_kind;
        n_idx  = 1'b0;
      end
    end

    if (!en) begin
      n_pend    = 1'b0;
      n_idx     = 1'b0;
      n_requeue = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      kind    <= KIND_XON;
      idx     <= 1'b0;
      requeue <= 1'b0;
      rq_kind <= KIND_XON;
    end else begin
      pend    <= n_pend;
      kind    <= n_kind;
      idx     <= n_idx;
      requeue <= n_requeue;
      rq_kind <= n_rq_kind;
    end
  end

endmodule

// File: rtl/xcg_code_sel.sv
module xcg_code_sel (
  input  logic [1:0]          tx_mode,
  input  logic                idx,
  input  xcg_pkg::code_kind_e kind,
  input  logic [7:0]          xon1,
  input  logic [7:0]          xon2,
  input  logic [7:0]          xoff1,
  input  logic [7:0]          xoff2,
  input  logic [1:0]          word_len,
  output logic [7:0]          code
);
  import xcg_pkg::*;

  logic       use_second;
  logic [7:0] raw;

  always_comb begin
    use_second = (tx_mode == 2'b01) || (tx_mode == 2'b11 && idx);
    if (kind == KIND_XOFF) raw = use_second ? xoff2 : xoff1;
    else                   raw = use_second ? xon2  : xon1;
    code = raw & len_mask(word_len);
  end

endmodule

// File: rtl/xcode_tx_sched.sv
module xcode_tx_sched #(
  parameter  int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_th,
  input  logic [LVL_W-1:0] resume_th,
  input  logic             use_trig,
  input  logic [1:0]       trig_sel,
  input  logic [1:0]       tx_mode,
  input  logic [7:0]       xon1,
  input  logic [7:0]       xon2,
  input  logic [7:0]       xoff1,
  input  logic [7:0]       xoff2,
  input  logic [1:0]       word_len,
  input  logic             tx_ready,
  output logic             inj_valid,
  output logic [7:0]       inj_code,
  output logic             fifo_go
);
  import xcg_pkg::*;

  // named internal events, visible to the bound checker
  logic       en, pair_mode, accept;
  logic       xoff_state, ev_halt, ev_resume;
  logic       pend, seq_idx;
  code_kind_e pend_kind;

  assign en        = |tx_mode;
  assign pair_mode = &tx_mode;
  assign accept    = tx_ready && pend;

  xcg_level_mon #(.DEPTH(DEPTH), .LVL_W(LVL_W)) mon_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_level(rx_level),
    .halt_th(halt_th), .resume_th(resume_th), .use_trig(use_trig),
    .trig_sel(trig_sel), .xoff_q(xoff_state), .ev_halt(ev_halt),
    .ev_resume(ev_resume)
  );

  xcg_seq seq_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pair_mode(pair_mode),
    .ev_halt(ev_halt), .ev_resume(ev_resume), .accept(accept),
    .pend(pend), .kind(pend_kind), .idx(seq_idx)
  );

  xcg_code_sel sel_i (
    .tx_mode(tx_mode), .idx(seq_idx), .kind(pend_kind),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .word_len(word_len), .code(inj_code)
  );

  assign inj_valid = pend;
  assign fifo_go   = tx_ready && !pend;

endmodule

// File: rtl/xcode_tx_sched_chk.sv
module xcode_tx_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_mode,
  input logic [1:0] word_len,
  input logic       tx_ready,
  input logic       inj_valid,
  input logic [7:0] inj_code,
  input logic       fifo_go,
  input logic       ev_halt,
  input logic       ev_resume,
  input logic       xoff_state,
  input logic       seq_idx
);

  p_halt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> xoff_state);

  p_resume_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> !xoff_state);

  p_off_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == 2'b00) |=> !inj_valid);

  p_trunc5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && word_len == 2'b00) |-> (inj_code[7:5] == 3'b000));

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> !fifo_go);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !tx_ready && tx_mode != 2'b00) |=> inj_valid);

  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && tx_ready && tx_mode == 2'b11 && !seq_idx) |=> (inj_valid && seq_idx));

endmodule

bind xcode_tx_sched xcode_tx_sched_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .word_len(word_len),
  .tx_ready(tx_ready), .inj_valid(inj_valid), .inj_code(inj_code),
  .fifo_go(fifo_go), .ev_halt(ev_halt), .ev_resume(ev_resume),
  .xoff_state(xoff_state), .seq_idx(seq_idx)
);

// File: tb/xcode_tx_sched_tb_top.sv
`timescale 1ns/1ps
module xcode_tx_sched_tb_top;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam logic [7:0] C_ON1 = 8'hD1, C_ON2 = 8'hB3, C_OFF1 = 8'hE5, C_OFF2 = 8'h97;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] rx_level = '0, halt_th = '0, resume_th = '0;
  logic use_trig = 1'b0, tx_ready = 1'b0;
  logic [1:0] trig_sel = '0, tx_mode = '0, word_len = 2'd3;
  logic inj_valid, fifo_go;
  logic [7:0] inj_code;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  xcode_tx_sched #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .halt_th(halt_th),
    .resume_th(resume_th), .use_trig(use_trig), .trig_sel(trig_sel),
    .tx_mode(tx_mode), .xon1(C_ON1), .xon2(C_ON2), .xoff1(C_OFF1),
    .xoff2(C_OFF2), .word_len(word_len), .tx_ready(tx_ready),
    .inj_valid(inj_valid), .inj_code(inj_code), .fifo_go(fifo_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic int trunc(input int c, input int wl);
    return c % (1 << (5 + wl));
  endfunction

  function automatic int ladder(input int sel);
    if (sel == 0) return DEPTH >> 3;
    if (sel == 1) return DEPTH >> 2;
    if (sel == 2) return DEPTH - (DEPTH >> 3);
    return DEPTH - (DEPTH >> 4);
  endfunction

  // take one offered code, checking priority over FIFO data
  task automatic take_one();
    tx_ready = 1'b1; #1;
    chk(fifo_go == 1'b0, "R7 fifo blocked", fifo_go, 0);
    tick();
    tx_ready = 1'b0; #1;
  endtask

  // accept a whole sequence of the given kind (1 = pause)
  task automatic drain(input bit pause, input int mode, input int wl);
    int c1, c2, first;
    c1 = pause ? C_OFF1 : C_ON1;
    c2 = pause ? C_OFF2 : C_ON2;
    first = (mode == 1) ? c2 : c1;
    chk(inj_valid && inj_code == trunc(first, wl), "R5/R6 first code", inj_code, trunc(first, wl));
    take_one();
    if (mode == 3) begin
      chk(inj_valid && inj_code == trunc(c2, wl), "R8 second code", inj_code, trunc(c2, wl));
      take_one();
    end
    chk(!inj_valid, "R10 idle after sequence", inj_valid, 0);
  endtask

  task automatic run_case(input int src, input int sel, input int mode, input int wl);
    int got, exp_up, exp_dn;
    use_trig = src[0]; trig_sel = sel[1:0]; tx_mode = mode[1:0]; word_len = wl[1:0];
    halt_th = LW'(3 + 3 * sel); resume_th = LW'(2 * sel);
    rx_level = '0;
    tick(); tick();
    chk(!inj_valid, "R2 quiet at empty", inj_valid, 0);
    exp_up = src ? ladder(sel) + 1 : 3 + 3 * sel + 1;
    exp_dn = src ? ladder(sel) / 2 - 1 : 2 * sel;
    got = -1;
    for (int l = 0; l <= DEPTH; l++) begin
      if (got < 0) begin
        rx_level = LW'(l); tick();
        if (inj_valid) got = l;
      end
    end
    chk(got == exp_up, src ? "R4 pause step" : "R2 pause limit", got, exp_up);
    drain(1'b1, mode, wl);
    rx_level = LW'(DEPTH);
    tick(); tick(); tick();
    chk(!inj_valid, "R2 no repeat", inj_valid, 0);
    got = -1;
    for (int l = DEPTH; l >= 0; l--) begin
      if (got < 0) begin
        rx_level = LW'(l); tick();
        if (inj_valid) got = l;
      end
    end
    chk(got == exp_dn, src ? "R4 resume step" : "R3 resume limit", got, exp_dn);
    drain(1'b0, mode, wl);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all R): actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tx_mode = 2'b10; rx_level = LW'(DEPTH); halt_th = LW'(4);
    #1;
    chk(!inj_valid, "R1 reset valid", inj_valid, 0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    rx_level = '0; tick();
    chk(!inj_valid, "R1 no pause state after reset", inj_valid, 0);
    tx_ready = 1'b1; #1;
    chk(fifo_go == 1'b1, "R7 fifo passes when idle", fifo_go, 1);
    tx_ready = 1'b0;

    // mode 00 never offers a code
    tx_mode = 2'b00; use_trig = 1'b0; halt_th = LW'(3); resume_th = LW'(1);
    for (int l = 0; l <= DEPTH; l++) begin
      rx_level = LW'(l); tick();
      chk(!inj_valid, "R5 mode off", inj_valid, 0);
    end
    rx_level = '0; tick();

    // exhaustive sweep
    for (int src = 0; src < 2; src++)
      for (int sel = 0; sel < 4; sel++)
        for (int mode = 1; mode < 4; mode++)
          for (int wl = 0; wl < 4; wl++)
            run_case(src, sel, mode, wl);

    // replacement of an unsent code
    tx_mode = 2'b10; use_trig = 1'b0; word_len = 2'd3;
    halt_th = LW'(9); resume_th = LW'(4); rx_level = '0;
    tick();
    rx_level = LW'(12); tick();
    chk(inj_valid && inj_code == C_OFF1, "R9 pause queued", inj_code, C_OFF1);
    tick();
    chk(inj_valid && inj_code == C_OFF1, "R7 held until taken", inj_code, C_OFF1);
    rx_level = LW'(2); tick();
    chk(inj_valid && inj_code == C_ON1, "R9 replaced by continue", inj_code, C_ON1);
    take_one();
    chk(!inj_valid, "R10 single taken", inj_valid, 0);
    rx_level = LW'(12); tick();
    chk(inj_valid && inj_code == C_OFF1, "R9 pause again after replace", inj_code, C_OFF1);
    take_one();
    chk(!inj_valid, "R10 idle", inj_valid, 0);

    finish_run();
  end

endmodule